// File: doc/BRIEF.md
# DDR Read-Window Strobe Generator

This block drives the read-window strobe of a DDR read path that runs at half the memory clock rate. Each system-clock cycle it presents a two-bit word, and each bit of that word covers one memory-clock slot. Bit 0 is the earlier slot and bit 1 the later one. The receive logic uses the strobe to gate the incoming data strobe and to mark the cycles that carry valid read data.

A read command is a single-cycle pulse. It comes with a burst kind (four or eight beats), a count of bursts, a whole-cycle delay, and a half-phase flag. The delay places the window a chosen number of system cycles after the command. The half-phase flag moves the window by one memory slot, so it can be placed at half-system-clock resolution. The window lasts one system cycle for each four beats of the total burst. A training sequence steps the delay and the phase until the capture side reports a correct window. Both knobs therefore have to take effect exactly, cycle by cycle.

Only one window runs at a time. A command that arrives while a window is pending or running is dropped, and a one-cycle error pulse is raised.

Top module: `read_window_strobe`

## Requirements
- R1: After reset, read_bits is 2'b00, and busy and cmd_err are low.
- R2: Bit 0 of read_bits is the earlier memory slot and bit 1 the later slot. A half-phase window opens with 2'b10 and closes with 2'b01.
- R3: With half_phase low, the window is L consecutive cycles of 2'b11. L = burst_cnt+1 for burst_kind 0 (four beats) and L = 2*(burst_cnt+1) for burst_kind 1 (eight beats), which is the total beat count divided by four.
- R4: If an accepted rd_cmd is sampled at clock edge k, the first window cycle is the cycle that begins at edge k+delay_cycles. A delay of 0 puts it in the cycle right after the command.
- R5: With half_phase high, the window is L+1 cycles: 2'b10, then L-1 cycles of 2'b11, then 2'b01. It asserts the same 2L slots as the unshifted window. Only a half-phase window ever shows a single set bit.
- R6: busy rises in the cycle after an accepted rd_cmd and stays high until the last window cycle is over. It is low from the next cycle on, when a new command is accepted again.
- R7: A rd_cmd sampled while busy is high leaves the running window and its length unchanged. cmd_err is then high for exactly the one following cycle.
- R8: read_bits is 2'b00 whenever no window cycle is in progress, including during the delay.
- R9: cmd_err stays low after any edge at which rd_cmd was not sampled while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_cmd | input | 1 | One-cycle read command pulse |
| burst_kind | input | 1 | 0 = four-beat bursts, 1 = eight-beat bursts |
| burst_cnt | input | CNT_W | Number of bursts minus one |
| delay_cycles | input | DLY_W | Whole system cycles from the command to the window |
| half_phase | input | 1 | Shift the window one memory slot later |
| read_bits | output | 2 | Strobe word; bit 0 earlier slot, bit 1 later slot |
| busy | output | 1 | A window is pending or in progress |
| cmd_err | output | 1 | One-cycle pulse after a command dropped while busy |

## Verification
Commands with random burst kinds, counts, delays and phases are compared cycle by cycle against a window computed in the bench. Because lengths and delays vary, an off-by-one in the length arithmetic or the delay count shows up as a shifted or clipped window. Directed cases cover the shortest window (one cycle, with and without the half shift), the longest delay with the longest burst, and back-to-back commands that start the cycle after busy falls. Commands dropped during the delay, in mid-window and in the very last window cycle check that the window survives unchanged and that the error pulse lands in the right cycle. That also separates a correct busy boundary from one cycle early or late.

// File: rtl/rws_pkg.sv
package rws_pkg;
  typedef enum logic [1:0] {
    RWS_IDLE   = 2'd0,
    RWS_WAIT   = 2'd1,
    RWS_ACTIVE = 2'd2
  } rws_state_e;

  localparam int RWS_GEAR = 2;
endpackage

// File: rtl/rws_span_calc.sv
module rws_span_calc #(
  parameter int CNT_W  = 3,
  parameter int SPAN_W = CNT_W + 2
) (
  input  logic              burst_kind,
  input  logic [CNT_W-1:0]  burst_cnt,
  input  logic              half_phase,
  output logic [SPAN_W-1:0] span
);
  // cycles of the window: beats/4, plus one when shifted by a slot
  function automatic logic [SPAN_W-1:0] window_span(
    input logic             kind,
    input logic [CNT_W-1:0] cnt,
    input logic             half
  );
    logic [SPAN_W-1:0] bursts;
    logic [SPAN_W-1:0] cycles;
    bursts = SPAN_W'(cnt) + SPAN_W'(1);
    cycles = kind ? (bursts << 1) : bursts;
    return cycles + SPAN_W'(half);
  endfunction

  assign span = window_span(burst_kind, burst_cnt, half_phase);
endmodule

// File: rtl/rws_sequencer.sv
module rws_sequencer
  import rws_pkg::*;
#(
  parameter int DLY_W  = 4,
  parameter int SPAN_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_cmd,
  input  logic [DLY_W-1:0]  delay_cycles,
  input  logic [SPAN_W-1:0] span_in,
  input  logic              half_in,
  output rws_state_e        state,
  output logic [SPAN_W-1:0] slot_idx,
  output logic [SPAN_W-1:0] span_q,
  output logic              half_q,
  output logic              accept,
  output logic              reject,
  output logic              cmd_err
);
  logic [DLY_W-1:0] wait_cnt;
  logic             idx_at_end;

  assign accept     = rd_cmd && (state == RWS_IDLE);
  assign reject     = rd_cmd && (state != RWS_IDLE);
  assign idx_at_end = (slot_idx == span_q - SPAN_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= RWS_IDLE;
      wait_cnt <= '0;
      slot_idx <= '0;
      span_q   <= '0;
      half_q   <= 1'b0;
      cmd_err  <= 1'b0;
    end else begin
      cmd_err <= reject;
      unique case (state)
        RWS_IDLE: begin
          if (accept) begin
            span_q   <= span_in;
            half_q   <= half_in;
            slot_idx <= '0;
            if (delay_cycles == '0) begin
              state <= RWS_ACTIVE;
            end else begin
              state    <= RWS_WAIT;
              wait_cnt <= delay_cycles - DLY_W'(1);
            end
          end
        end
        RWS_WAIT: begin
          if (wait_cnt == '0) state <= RWS_ACTIVE;
          else                wait_cnt <= wait_cnt - DLY_W'(1);
        end
        RWS_ACTIVE: begin
          if (idx_at_end) begin
            state    <= RWS_IDLE;
            slot_idx <= '0;
          end else begin
            slot_idx <= slot_idx + SPAN_W'(1);
          end
        end
        default: state <= RWS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rws_pattern.sv
module rws_pattern
  import rws_pkg::*;
(
  input  logic                active,
  input  logic                first,
  input  logic                last,
  input  logic                half,
  output logic [RWS_GEAR-1:0] bits
);
  // slot 0 is dropped at the head of a shifted window, the last slot at its tail
  for (genvar b = 0; b < RWS_GEAR; b++) begin : g_slot
    if (b == 0) begin : g_lead
      assign bits[b] = active && !(half && first);
    end else if (b == RWS_GEAR - 1) begin : g_trail
      assign bits[b] = active && !(half && last);
    end else begin : g_mid
      assign bits[b] = active;
    end
  end
endmodule

// File: rtl/read_window_strobe.sv
module read_window_strobe
  import rws_pkg::*;
#(
  parameter int CNT_W = 3,
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_cmd,
  input  logic             burst_kind,
  input  logic [CNT_W-1:0] burst_cnt,
  input  logic [DLY_W-1:0] delay_cycles,
  input  logic             half_phase,
  output logic [1:0]       read_bits,
  output logic             busy,
  output logic             cmd_err
);
  localparam int SPAN_W = CNT_W + 2;

  logic [SPAN_W-1:0] span_in;
  logic [SPAN_W-1:0] span_q;
  logic [SPAN_W-1:0] slot_idx;
  logic              half_q;
  logic              accept;
  logic              reject;
  rws_state_e        state;

  // named window events, used by the pattern and the checker
  logic win_active;
  logic win_first;
  logic win_last;

  rws_span_calc #(.CNT_W(CNT_W), .SPAN_W(SPAN_W)) u_span (
    .burst_kind (burst_kind),
    .burst_cnt  (burst_cnt),
    .half_phase (half_phase),
    .span       (span_in)
  );

  rws_sequencer #(.DLY_W(DLY_W), .SPAN_W(SPAN_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_cmd       (rd_cmd),
    .delay_cycles (delay_cycles),
    .span_in      (span_in),
    .half_in      (half_phase),
    .state        (state),
    .slot_idx     (slot_idx),
    .span_q       (span_q),
    .half_q       (half_q),
    .accept       (accept),
    .reject       (reject),
    .cmd_err      (cmd_err)
  );

  assign win_active = (state == RWS_ACTIVE);
  assign win_first  = win_active && (slot_idx == '0);
  assign win_last   = win_active && (slot_idx == span_q - SPAN_W'(1));
  assign busy       = (state != RWS_IDLE);

  rws_pattern u_pat (
    .active (win_active),
    .first  (win_first),
    .last   (win_last),
    .half   (half_q),
    .bits   (read_bits)
  );
endmodule

// File: rtl/rws_checker.sv
module rws_checker #(
  parameter int SPAN_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_cmd,
  input logic              busy,
  input logic              cmd_err,
  input logic [1:0]        read_bits,
  input logic              win_first,
  input logic              win_last,
  input logic              half_q,
  input logic [SPAN_W-1:0] span_q
);
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!busy && !cmd_err && read_bits == 2'b00));

  assert_quiet_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (read_bits == 2'b00));

  assert_start_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cmd && !busy) |=> busy);

  assert_err_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cmd && busy) |=> cmd_err);

  assert_span_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cmd && busy) |=> $stable(span_q));

  assert_err_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_cmd && busy) |=> !cmd_err);

  assert_single_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(read_bits) == 1) |-> half_q);

  assert_lead_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (win_first && half_q) |-> (read_bits == 2'b10));

  assert_tail_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (win_last && half_q) |-> (read_bits == 2'b01));
endmodule

bind read_window_strobe rws_checker #(.SPAN_W(SPAN_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_cmd    (rd_cmd),
  .busy      (busy),
  .cmd_err   (cmd_err),
  .read_bits (read_bits),
  .win_first (win_first),
  .win_last  (win_last),
  .half_q    (half_q),
  .span_q    (span_q)
);

// File: tb/read_window_strobe_bench.sv
`timescale 1ns/1ps
module read_window_strobe_bench;
  localparam int CNT_W = 3;
  localparam int DLY_W = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             rd_cmd = 1'b0;
  logic             burst_kind = 1'b0;
  logic [CNT_W-1:0] burst_cnt = '0;
  logic [DLY_W-1:0] delay_cycles = '0;
  logic             half_phase = 1'b0;
  logic [1:0]       read_bits;
  logic             busy;
  logic             cmd_err;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  read_window_strobe #(.CNT_W(CNT_W), .DLY_W(DLY_W)) u_read_window_strobe (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_cmd       (rd_cmd),
    .burst_kind   (burst_kind),
    .burst_cnt    (burst_cnt),
    .delay_cycles (delay_cycles),
    .half_phase   (half_phase),
    .read_bits    (read_bits),
    .busy         (busy),
    .cmd_err      (cmd_err)
  );

  // window cycles from the beat count: one per four beats, plus one if shifted
  function automatic int exp_span(input int kind, input int cnt, input int half);
    int beats;
    beats = (cnt + 1) * (kind != 0 ? 8 : 4);
    return beats / 4 + half;
  endfunction

  function automatic int exp_bits(input int i, input int d, input int r, input int half);
    if (i < d || i >= d + r) return 0;
    if (half == 0) return 3;
    if (i == d) return 2;
    if (i == d + r - 1) return 1;
    return 3;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // issue one command at the current negedge, then follow its window;
  // inj >= 0 drops an extra command (with scrambled fields) in that window cycle
  task automatic run_window(input int kind, input int cnt, input int dly,
                            input int half, input int inj);
    int r;
    int slots;
    r = exp_span(kind, cnt, half);
    slots = 0;
    burst_kind   = kind[0];
    burst_cnt    = CNT_W'(cnt);
    delay_cycles = DLY_W'(dly);
    half_phase   = half[0];
    rd_cmd       = 1'b1;
    for (int i = 0; i <= dly + r; i++) begin
      int eb;
      @(negedge clk);
      eb = exp_bits(i, dly, r, half);
      if (i < dly || i >= dly + r)      chk("R8 bits outside window", int'(read_bits), eb);
      else if (i == dly && half != 0)   chk("R2 shifted window head", int'(read_bits), eb);
      else if (i == dly)                chk("R4 window start after delay", int'(read_bits), eb);
      else if (half != 0)               chk("R5 shifted window body", int'(read_bits), eb);
      else                              chk("R3 window body", int'(read_bits), eb);
      chk("R6 busy", int'(busy), (i < dly + r) ? 1 : 0);
      if (inj >= 0 && i == inj + 1) chk("R7 error pulse", int'(cmd_err), 1);
      else                          chk("R9 error quiet", int'(cmd_err), 0);
      slots += $countones(read_bits);
      rd_cmd = (i == inj);
      if (i == inj) begin
        burst_kind   = ~burst_kind;
        burst_cnt    = CNT_W'($urandom);
        delay_cycles = DLY_W'($urandom);
        half_phase   = ~half_phase;
      end
    end
    rd_cmd = 1'b0;
    chk(half != 0 ? "R5 slot total" : "R3 slot total", slots, 2 * exp_span(kind, cnt, 0));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    chk("R1 reset bits", int'(read_bits), 0);
    chk("R1 reset busy", int'(busy), 0);
    chk("R1 reset err", int'(cmd_err), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 post-reset bits", int'(read_bits), 0);
    chk("R1 post-reset busy", int'(busy), 0);

    // directed corners
    run_window(0, 0, 0, 0, -1);   // shortest window
    run_window(0, 0, 0, 1, -1);   // shortest shifted window: 10 then 01
    run_window(1, 7, 15, 1, -1);  // longest delay and burst
    run_window(1, 0, 2, 0, 0);    // dropped during the delay
    run_window(0, 3, 1, 0, 4);    // dropped in the last window cycle
    run_window(1, 2, 0, 1, 3);    // dropped mid-window
    run_window(0, 1, 0, 0, -1);   // back-to-back after busy falls

    for (int n = 0; n < 60; n++) begin
      int k, c, d, h, r, inj;
      k = int'($urandom % 2);
      c = int'($urandom % 8);
      d = int'($urandom % 16);
      h = int'($urandom % 2);
      r = exp_span(k, c, h);
      inj = ($urandom % 3 == 0) ? int'($urandom % (d + r)) : -1;
      run_window(k, c, d, h, inj);
      if ($urandom % 2 == 0) begin
        for (int g = 0; g < 2; g++) begin
          @(negedge clk);
          chk("R8 idle gap bits", int'(read_bits), 0);
          chk("R6 idle gap busy", int'(busy), 0);
        end
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule